// File: doc/BRIEF.md
# Multiplexed Video Input Formatter

This block sits at the front of a video encoder. It accepts 8-bit component video samples on a 27 MHz clock and rebuilds whole pixels at the 13.5 MHz pixel rate. Each pixel comes out as one luma byte and a pair of colour-difference bytes, Cb and Cr. Two pixels share each Cb/Cr pair. A valid strobe marks each output pixel.

Two input arrangements are supported. In the default arrangement, one port carries bytes interleaved as Cb, Y, Cr, Y, and so on. In the split arrangement, the main port carries luma only and an auxiliary port carries Cb and Cr bytes in turn. The 27 MHz edges that belong to the pixel-rate phase come from one of two sources. Either an external qualifier input marks them, or the block divides the clock by two itself. A start-of-line pulse sets the chroma order. The block does not search the data for embedded timing-reference codes, so such bytes pass through as ordinary samples.

A pixel is emitted once the luma of the next pixel arrives. By then the Cr byte of its pair is known.

Top module: `vid_in_fmt`

## Requirements
- R1: While rst_ni is low, valid_o, y_o, cb_o and cr_o are all 0.
- R2: With split_mode_i=0, each slot cycle (slot_o=1) takes a luma byte from main_d_i and each other cycle takes a chroma byte from main_d_i. The bytes cycle in the order Cb, Y, Cr, Y. Each pixel pair is output with its own Cb and Cr.
- R3: Pixel k is presented on y_o, with valid_o=1 for exactly one cycle, after the clock edge that accepts the luma of pixel k+1. Cycles that are not slot cycles give valid_o=0.
- R4: Both pixels of a pair carry the same cb_o and cr_o. When the odd pixel is output, cb_o and cr_o do not change.
- R5: With split_mode_i=1, each slot cycle takes Y from main_d_i and a chroma byte from aux_d_i, Cb first and then Cr in turn. Non-slot cycles are ignored.
- R6: With qual_en_i=1, a cycle is a slot cycle exactly when qual_i=1, whatever the pattern of qual_i.
- R7: With qual_en_i=0, slot cycles alternate with non-slot cycles. A sol_i pulse resets this phase: the sol_i cycle is a non-slot cycle when split_mode_i=0 and a slot cycle when split_mode_i=1.
- R8: The chroma byte taken in a sol_i cycle is always Cb, whatever the chroma order was before.
- R9: Byte values used as timing codes (0xFF, 0x00, 0x00, 0x80) are treated as ordinary samples.
- R10: valid_o stays 0 after reset until a sol_i pulse has been seen.
- R11: While valid_o is 0, y_o, cb_o and cr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 27 MHz sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_mode_i | input | 1 | 0: interleaved on main port; 1: luma on main, chroma on aux |
| qual_en_i | input | 1 | 1: pixel phase taken from qual_i |
| qual_i | input | 1 | External clock qualifier, high on slot edges |
| sol_i | input | 1 | Start of line, marks the first Cb byte of a line |
| main_d_i | input | 8 | Main sample port |
| aux_d_i | input | 8 | Chroma port in split mode |
| y_o | output | 8 | Luma of output pixel |
| cb_o | output | 8 | Cb of output pixel pair |
| cr_o | output | 8 | Cr of output pixel pair |
| valid_o | output | 1 | Pixel strobe |

## Verification
Every output is one register stage behind the edge that accepts the luma of the following pixel. A pixel's results are therefore due just after that edge. Only the strobe drops after a chroma-only or ignored edge. The bench drives each byte half a cycle before the edge that accepts it and reads the outputs half a cycle after that edge. Each step is compared with the pixel that step must release, or with the held values when no pixel is due.

// File: rtl/vif_pkg.sv
package vif_pkg;
  typedef enum logic {
    CSEL_CB = 1'b0,
    CSEL_CR = 1'b1
  } csel_e;
endpackage

// File: rtl/vif_phase.sv
module vif_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic split_mode_i,
  input  logic qual_en_i,
  input  logic qual_i,
  input  logic sol_i,
  output logic slot_o
);
  logic tog_q;
  logic slot_int;

  // sol_i forces the phase: chroma byte in interleaved mode, full pixel in split mode
  assign slot_int = sol_i ? split_mode_i : tog_q;
  assign slot_o   = qual_en_i ? qual_i : slot_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~slot_int;
  end

  AST_PHASE_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !qual_en_i && !sol_i && $past(!qual_en_i) && $past(!sol_i))
      |-> (slot_o != $past(slot_o))); // R7

  AST_QUAL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_en_i |-> (slot_o == qual_i)); // R6
endmodule

// File: rtl/vif_chroma.sv
module vif_chroma
  import vif_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          split_mode_i,
  input  logic          slot_i,
  input  logic          sol_i,
  input  logic [DW-1:0] main_d_i,
  input  logic [DW-1:0] aux_d_i,
  output logic [DW-1:0] cb_now_o,
  output logic [DW-1:0] cr_now_o
);
  logic [DW-1:0] cb_q, cr_q, c_byte;
  csel_e         csel_q, sel;
  logic          cap;

  assign c_byte = split_mode_i ? aux_d_i : main_d_i;
  assign cap    = split_mode_i ? slot_i : ~slot_i;
  assign sel    = sol_i ? CSEL_CB : csel_q;

  // bypass so a pair completing this cycle is usable at once
  assign cb_now_o = (cap && sel == CSEL_CB) ? c_byte : cb_q;
  assign cr_now_o = (cap && sel == CSEL_CR) ? c_byte : cr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cb_q   <= '0;
      cr_q   <= '0;
      csel_q <= CSEL_CB;
    end else if (cap) begin
      if (sel == CSEL_CB) cb_q <= c_byte;
      else                cr_q <= c_byte;
      csel_q <= (sel == CSEL_CB) ? CSEL_CR : CSEL_CB;
    end else if (sol_i) begin
      csel_q <= CSEL_CB;
    end
  end

  AST_SOL_IS_CB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_i && cap) |=> (cb_q == $past(c_byte))); // R8

  AST_SOL_NEXT_CR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_i && cap) |=> (csel_q == CSEL_CR)); // R8
endmodule

// File: rtl/vif_pixel.sv
module vif_pixel #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_i,
  input  logic          sol_i,
  input  logic [DW-1:0] main_d_i,
  input  logic [DW-1:0] cb_now_i,
  input  logic [DW-1:0] cr_now_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o,
  output logic          valid_o
);
  logic [DW-1:0] y_prev_q;
  logic          prev_odd_q, prev_vld_q, par_q, armed_q, out_odd_q;
  logic          cur_par, armed;

  assign cur_par = sol_i ? 1'b0 : par_q;
  assign armed   = armed_q | sol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_prev_q   <= '0;
      prev_odd_q <= 1'b0;
      prev_vld_q <= 1'b0;
      par_q      <= 1'b0;
      armed_q    <= 1'b0;
      out_odd_q  <= 1'b0;
      y_o        <= '0;
      cb_o       <= '0;
      cr_o       <= '0;
      valid_o    <= 1'b0;
    end else begin
      armed_q <= armed;
      if (slot_i) begin
        y_prev_q   <= main_d_i;
        prev_odd_q <= cur_par;
        prev_vld_q <= armed;
        par_q      <= ~cur_par;
        valid_o    <= prev_vld_q;
        if (prev_vld_q) begin
          y_o       <= y_prev_q;
          out_odd_q <= prev_odd_q;
          // even pixel latches the completed pair; odd pixel reuses it
          if (!prev_odd_q) begin
            cb_o <= cb_now_i;
            cr_o <= cr_now_i;
          end
        end
      end else begin
        valid_o <= 1'b0;
        if (sol_i) par_q <= 1'b0;
      end
    end
  end

  AST_VALID_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> armed_q); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(y_o) && $stable(cb_o) && $stable(cr_o))); // R11

  AST_PAIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_odd_q) |-> ($stable(cb_o) && $stable(cr_o))); // R4

  AST_VALID_NEEDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !valid_o); // R3
endmodule

// File: rtl/vid_in_fmt.sv
module vid_in_fmt #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          split_mode_i,
  input  logic          qual_en_i,
  input  logic          qual_i,
  input  logic          sol_i,
  input  logic [DW-1:0] main_d_i,
  input  logic [DW-1:0] aux_d_i,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o,
  output logic          valid_o
);
  logic          slot;
  logic [DW-1:0] cb_now, cr_now;

  vif_phase i_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .split_mode_i (split_mode_i),
    .qual_en_i    (qual_en_i),
    .qual_i       (qual_i),
    .sol_i        (sol_i),
    .slot_o       (slot)
  );

  vif_chroma #(.DW(DW)) i_chroma (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .split_mode_i (split_mode_i),
    .slot_i       (slot),
    .sol_i        (sol_i),
    .main_d_i     (main_d_i),
    .aux_d_i      (aux_d_i),
    .cb_now_o     (cb_now),
    .cr_now_o     (cr_now)
  );

  vif_pixel #(.DW(DW)) i_pixel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot_i   (slot),
    .sol_i    (sol_i),
    .main_d_i (main_d_i),
    .cb_now_i (cb_now),
    .cr_now_i (cr_now),
    .y_o      (y_o),
    .cb_o     (cb_o),
    .cr_o     (cr_o),
    .valid_o  (valid_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !valid_o); // R1
endmodule

// File: tb/test_vid_in_fmt.sv
module test_vid_in_fmt;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       split_mode_i = 1'b0;
  logic       qual_en_i = 1'b0;
  logic       qual_i = 1'b0;
  logic       sol_i = 1'b0;
  logic [7:0] main_d_i = '0;
  logic [7:0] aux_d_i = '0;
  logic [7:0] y_o, cb_o, cr_o;
  logic       valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vid_in_fmt i_vid_in_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .split_mode_i(split_mode_i),
    .qual_en_i(qual_en_i), .qual_i(qual_i), .sol_i(sol_i),
    .main_d_i(main_d_i), .aux_d_i(aux_d_i),
    .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic ev, input logic [7:0] ey,
                     input logic [7:0] ecb, input logic [7:0] ecr);
    n_chk++;
    if ({valid_o, y_o, cb_o, cr_o} !== {ev, ey, ecb, ecr}) begin
      n_err++;
      $display("FAIL %s: got v=%0b y=%h cb=%h cr=%h, exp v=%0b y=%h cb=%h cr=%h",
               req, valid_o, y_o, cb_o, cr_o, ev, ey, ecb, ecr);
    end
  endtask

  task automatic chk_v(input string req, input logic ev);
    n_chk++;
    if (valid_o !== ev) begin
      n_err++;
      $display("FAIL %s: got v=%0b, exp v=%0b", req, valid_o, ev);
    end
  endtask

  // drive at negedge, accept at posedge, observe at next negedge
  task automatic step(input logic [7:0] m, input logic [7:0] a, input logic s, input logic q);
    main_d_i = m; aux_d_i = a; sol_i = s; qual_i = q;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset(input logic split, input logic qen);
    @(negedge clk_i);
    rst_ni = 1'b0; sol_i = 1'b0; qual_i = 1'b0;
    split_mode_i = split; qual_en_i = qen;
    main_d_i = 8'h5A; aux_d_i = 8'hA5;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 reset", 1'b0, 8'h00, 8'h00, 8'h00);
    rst_ni = 1'b1;
  endtask

  task automatic t_no_sol;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(8'h30 + 8'(i), 8'h00, 1'b0, 1'b0);
      chk("R10 no line start", 1'b0, 8'h00, 8'h00, 8'h00);
    end
  endtask

  task automatic t_single;
    do_reset(1'b0, 1'b0);
    step(8'h10, 8'h00, 1'b1, 1'b0); chk("R2 Cb0", 1'b0, 8'h00, 8'h00, 8'h00);
    step(8'h20, 8'h00, 1'b0, 1'b0); chk("R10 first luma", 1'b0, 8'h00, 8'h00, 8'h00);
    step(8'h30, 8'h00, 1'b0, 1'b0); chk("R11 Cr0 hold", 1'b0, 8'h00, 8'h00, 8'h00);
    step(8'h21, 8'h00, 1'b0, 1'b0); chk("R2 R3 pixel0", 1'b1, 8'h20, 8'h10, 8'h30);
    step(8'h11, 8'h00, 1'b0, 1'b0); chk("R11 Cb1 hold", 1'b0, 8'h20, 8'h10, 8'h30);
    step(8'h22, 8'h00, 1'b0, 1'b0); chk("R4 pixel1 pair held", 1'b1, 8'h21, 8'h10, 8'h30);
    step(8'h31, 8'h00, 1'b0, 1'b0); chk("R3 no strobe on chroma", 1'b0, 8'h21, 8'h10, 8'h30);
    step(8'h23, 8'h00, 1'b0, 1'b0); chk("R2 pixel2", 1'b1, 8'h22, 8'h11, 8'h31);
    step(8'h12, 8'h00, 1'b0, 1'b0); chk("R11 hold", 1'b0, 8'h22, 8'h11, 8'h31);
    step(8'h24, 8'h00, 1'b0, 1'b0); chk("R4 pixel3", 1'b1, 8'h23, 8'h11, 8'h31);
  endtask

  task automatic t_codes;
    do_reset(1'b0, 1'b0);
    step(8'hFF, 8'h00, 1'b1, 1'b0);
    step(8'h00, 8'h00, 1'b0, 1'b0);
    step(8'h00, 8'h00, 1'b0, 1'b0);
    step(8'h80, 8'h00, 1'b0, 1'b0); chk("R9 code bytes as pixel", 1'b1, 8'h00, 8'hFF, 8'h00);
    step(8'h40, 8'h00, 1'b0, 1'b0);
    step(8'h50, 8'h00, 1'b0, 1'b0); chk("R9 code luma", 1'b1, 8'h80, 8'hFF, 8'h00);
  endtask

  task automatic t_split;
    do_reset(1'b1, 1'b0);
    step(8'h60, 8'h70, 1'b1, 1'b0); chk("R5 first slot", 1'b0, 8'h00, 8'h00, 8'h00);
    step(8'hEE, 8'hEE, 1'b0, 1'b0); chk("R7 off phase ignored", 1'b0, 8'h00, 8'h00, 8'h00);
    step(8'h61, 8'h71, 1'b0, 1'b0); chk("R5 pixel0", 1'b1, 8'h60, 8'h70, 8'h71);
    step(8'hEE, 8'hEE, 1'b0, 1'b0); chk("R7 off phase hold", 1'b0, 8'h60, 8'h70, 8'h71);
    step(8'h62, 8'h72, 1'b0, 1'b0); chk("R5 R4 pixel1", 1'b1, 8'h61, 8'h70, 8'h71);
    step(8'hEE, 8'hEE, 1'b0, 1'b0);
    step(8'h63, 8'h73, 1'b0, 1'b0); chk("R5 pixel2", 1'b1, 8'h62, 8'h72, 8'h73);
  endtask

  task automatic t_qual;
    do_reset(1'b1, 1'b1);
    step(8'h60, 8'h70, 1'b1, 1'b1);
    step(8'hEE, 8'hEE, 1'b0, 1'b0);
    step(8'hEE, 8'hEE, 1'b0, 1'b0); chk("R6 qual low ignored", 1'b0, 8'h00, 8'h00, 8'h00);
    step(8'h61, 8'h71, 1'b0, 1'b1); chk("R6 pixel0", 1'b1, 8'h60, 8'h70, 8'h71);
    step(8'h62, 8'h72, 1'b0, 1'b1); chk("R6 back to back", 1'b1, 8'h61, 8'h70, 8'h71);
    step(8'hEE, 8'hEE, 1'b0, 1'b0); chk("R6 idle", 1'b0, 8'h61, 8'h70, 8'h71);
    do_reset(1'b0, 1'b1);
    step(8'h10, 8'h00, 1'b1, 1'b0);
    step(8'h20, 8'h00, 1'b0, 1'b1);
    step(8'h30, 8'h00, 1'b0, 1'b0);
    step(8'h21, 8'h00, 1'b0, 1'b1); chk("R6 interleaved qual", 1'b1, 8'h20, 8'h10, 8'h30);
  endtask

  task automatic t_resync;
    do_reset(1'b0, 1'b0);
    step(8'h10, 8'h00, 1'b1, 1'b0);
    step(8'h20, 8'h00, 1'b0, 1'b0);
    step(8'h15, 8'h00, 1'b1, 1'b0); chk_v("R7 sol forces chroma phase", 1'b0);
    step(8'h25, 8'h00, 1'b0, 1'b0); chk_v("R7 luma after sol", 1'b1);
    step(8'h35, 8'h00, 1'b0, 1'b0);
    step(8'h26, 8'h00, 1'b0, 1'b0); chk("R8 sol restarts at Cb", 1'b1, 8'h25, 8'h15, 8'h35);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_no_sol();
    t_single();
    t_codes();
    t_split();
    t_qual();
    t_resync();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule